// File: doc/BRIEF.md
# Load/Store Line Merger

This block sits between a group of load/store units and a line-organised data cache. It keeps one fixed request slot for every load/store port (eight units with two ports each by default, the second port of a unit carrying the spill-over half of a misaligned access). Each slot holds a pending request: a valid flag, a byte address and an access size. The block combines requests that fall into the same cache line into one line-level access, so it needs no wide many-to-few request multiplexer.

A small two-state controller drives the output side. In `ST_IDLE` it waits. The transition *capture* (any slot valid) takes a snapshot of one merged access and moves to `ST_OFFER`. In `ST_OFFER` the access is held on the outputs. The transition *retire* (acknowledge seen) clears every served slot and returns to `ST_IDLE`. To form the merged access, a priority picker chooses the lowest-numbered valid slot. Every valid slot numbered above it joins the access when it matches the picked address from bit 4 upward. The per-slot byte masks of all joined slots are ORed into a 16-lane byte enable. Bit 4 of the picked address selects which 16-byte half of the 32-byte line those lanes cover.

Top module: `lsm_line_merger`

## Requirements
- R1: After reset `acc_valid` is 0 and every bit of `req_ready` is 1.
- R2: Exactly one slot is picked per access: the lowest-numbered valid slot. `acc_line` is its address bits [ADDR_W-1:5], `acc_half` is its address bit 4, and its bit in `acc_served` is set.
- R3: A valid slot with a higher number than the pick is served together with it exactly when its address bits [ADDR_W-1:4] equal those of the pick. Slots below the pick are never served.
- R4: Address bits 3:0 never take part in the match. A difference in any single bit from bit 4 up to bit ADDR_W-1 keeps a slot out of the access.
- R5: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. A slot's lane mask has lanes off through off+size-1 set, where off is address bits 3:0. Lanes above 15 are dropped. `acc_be` is the OR of the masks of all served slots.
- R6: A request accepted in one cycle is offered (`acc_valid` high) two clock edges later. While `acc_ack` is low the offered access stays unchanged. An `acc_ack` high at a clock edge clears every served slot, so those `req_ready` bits read 1 after that edge.
- R7: A slot accepts a request only while it is empty (`req_ready` high). A request to an occupied slot is ignored and is not kept for later.
- R8: A request written while an access is offered does not alter that access. It is picked after the retire.
- R9: Slots left over after a retire are offered in later accesses, again lowest-numbered first, until all are drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_UNITS*PORTS_PER_UNIT | Per-slot request strobe |
| req_addr | input | NUM_UNITS*PORTS_PER_UNIT*ADDR_W | Per-slot byte address, slot i in bits [i*ADDR_W +: ADDR_W] |
| req_len | input | NUM_UNITS*PORTS_PER_UNIT*2 | Per-slot size code (0:1B, 1:2B, 2:4B, 3:8B), slot i in bits [2i +: 2] |
| req_ready | output | NUM_UNITS*PORTS_PER_UNIT | Slot empty and able to take a request |
| acc_valid | output | 1 | A merged line access is offered |
| acc_line | output | ADDR_W-5 | Line address of the offered access |
| acc_half | output | 1 | Selects the 16-byte half of the line |
| acc_be | output | 16 | Byte-lane enables for that half |
| acc_served | output | NUM_UNITS*PORTS_PER_UNIT | Slots covered by the offered access |
| acc_ack | input | 1 | Access taken; retire the served slots |

## Verification
The assertions assume that `acc_ack` is raised only while `acc_valid` is high, and that it stays high for a single cycle per access. The stimulus therefore waits until it sees an offer before it pulses the acknowledge once. The hold checks also assume that requests are sized by the 2-bit code alone, and every code value is legal, so the bench drives all four sizes at all sixteen offsets. That includes the sizes that run past lane 15, where truncation is the defined behaviour. Requests that target occupied slots are issued on purpose, because the slot-hold assertion must keep holding when they arrive.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int LANES    = 16;
    localparam int OFF_W    = 4;
    localparam int HALF_BIT = 4;
    localparam int LINE_LSB = 5;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } size_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } merge_st_e;

    // Run of (1 << size) ones, moved up to the byte offset, clipped at lane 15.
    function automatic logic [LANES-1:0] lane_mask(input logic [OFF_W-1:0] off,
                                                   input logic [1:0] size);
        logic [31:0] run;
        logic [31:0] moved;
        run   = (32'd1 << (5'd1 << size)) - 32'd1;
        moved = run << off;
        return moved[LANES-1:0];
    endfunction

endpackage

// File: rtl/lsm_pick.sv
module lsm_pick #(
    parameter int W = 16
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant
);
    // Isolate the lowest set bit: lower slots win.
    assign grant = req & (~req + W'(1));
endmodule

// File: rtl/lsm_slots.sv
module lsm_slots #(
    parameter int N  = 16,
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         wr_req,
    input  logic [N-1:0][AW-1:0] wr_addr,
    input  logic [N-1:0][1:0]    wr_size,
    input  logic [N-1:0]         clr,
    output logic [N-1:0]         valid,
    output logic [N-1:0][AW-1:0] addr,
    output logic [N-1:0][1:0]    size
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        logic take;
        assign take = wr_req[i] & ~valid[i];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[i] <= 1'b0;
                addr[i]  <= '0;
                size[i]  <= '0;
            end else begin
                if (clr[i]) begin
                    valid[i] <= 1'b0;
                end else if (take) begin
                    valid[i] <= 1'b1;
                end
                if (take) begin
                    addr[i] <= wr_addr[i];
                    size[i] <= wr_size[i];
                end
            end
        end

        AST_SLOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (valid[i] && !clr[i]) |=> (valid[i] && $stable(addr[i]) && $stable(size[i]))); // R7
    end
endmodule

// File: rtl/lsm_merge.sv
module lsm_merge
    import lsm_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 32
) (
    input  logic [N-1:0]               valid,
    input  logic [N-1:0][AW-1:0]       addr,
    input  logic [N-1:0][1:0]          size,
    output logic [N-1:0]               pick,
    output logic [N-1:0]               served,
    output logic [AW-1:HALF_BIT]       pick_hi,
    output logic [LANES-1:0]           be
);
    logic [N-1:0] above;
    logic [N-1:0] join_row;

    lsm_pick #(.W(N)) u_pick (
        .req   (valid),
        .grant (pick)
    );

    // Upper address of the picked slot (pick is one-hot or zero).
    always_comb begin
        pick_hi = '0;
        for (int i = 0; i < N; i++) begin
            if (pick[i]) pick_hi = pick_hi | addr[i][AW-1:HALF_BIT];
        end
    end

    // Rows strictly above the pick.
    always_comb begin
        logic seen;
        seen  = 1'b0;
        above = '0;
        for (int j = 0; j < N; j++) begin
            above[j] = seen;
            seen     = seen | pick[j];
        end
    end

    // One-sided compare against the pick only.
    for (genvar j = 0; j < N; j++) begin : g_cmp
        assign join_row[j] = valid[j] & above[j] &
                             (addr[j][AW-1:HALF_BIT] == pick_hi);
    end

    assign served = pick | join_row;

    always_comb begin
        be = '0;
        for (int j = 0; j < N; j++) begin
            if (served[j]) be = be | lane_mask(addr[j][OFF_W-1:0], size[j]);
        end
    end
endmodule

// File: rtl/lsm_line_merger.sv
module lsm_line_merger
    import lsm_pkg::*;
#(
    parameter int NUM_UNITS      = 8,
    parameter int PORTS_PER_UNIT = 2,
    parameter int ADDR_W         = 32,
    localparam int N             = NUM_UNITS * PORTS_PER_UNIT,
    localparam int LINE_W        = ADDR_W - LINE_LSB
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          req_valid,
    input  logic [N*ADDR_W-1:0]   req_addr,
    input  logic [N*2-1:0]        req_len,
    output logic [N-1:0]          req_ready,
    output logic                  acc_valid,
    output logic [LINE_W-1:0]     acc_line,
    output logic                  acc_half,
    output logic [LANES-1:0]      acc_be,
    output logic [N-1:0]          acc_served,
    input  logic                  acc_ack
);
    logic [N-1:0][ADDR_W-1:0] in_addr;
    logic [N-1:0][1:0]        in_size;
    logic [N-1:0]             slot_valid;
    logic [N-1:0][ADDR_W-1:0] slot_addr;
    logic [N-1:0][1:0]        slot_size;
    logic [N-1:0]             slot_clr;

    logic [N-1:0]             m_pick;
    logic [N-1:0]             m_served;
    logic [ADDR_W-1:HALF_BIT] m_hi;
    logic [LANES-1:0]         m_be;

    merge_st_e state_q, state_d;
    logic      capture, retire;

    logic [ADDR_W-1:HALF_BIT] off_hi;
    logic [LANES-1:0]         off_be;
    logic [N-1:0]             off_served;

    assign in_addr = req_addr;
    assign in_size = req_len;

    lsm_slots #(.N(N), .AW(ADDR_W)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (req_valid),
        .wr_addr (in_addr),
        .wr_size (in_size),
        .clr     (slot_clr),
        .valid   (slot_valid),
        .addr    (slot_addr),
        .size    (slot_size)
    );

    lsm_merge #(.N(N), .AW(ADDR_W)) u_merge (
        .valid   (slot_valid),
        .addr    (slot_addr),
        .size    (slot_size),
        .pick    (m_pick),
        .served  (m_served),
        .pick_hi (m_hi),
        .be      (m_be)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs.
    always_comb begin
        state_d    = state_q;
        capture    = 1'b0;
        retire     = 1'b0;
        acc_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (|slot_valid) begin
                    capture = 1'b1;
                    state_d = ST_OFFER;
                end
            end
            ST_OFFER: begin
                acc_valid = 1'b1;
                if (acc_ack) begin
                    retire  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        slot_clr   = retire ? off_served : '0;
        req_ready  = ~slot_valid;
        acc_line   = off_hi[ADDR_W-1:LINE_LSB];
        acc_half   = off_hi[HALF_BIT];
        acc_be     = off_be;
        acc_served = off_served;
    end

    // Snapshot of the merged access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_hi     <= '0;
            off_be     <= '0;
            off_served <= '0;
        end else if (capture) begin
            off_hi     <= m_hi;
            off_be     <= m_be;
            off_served <= m_served;
        end
    end

    AST_ONE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_valid) |-> $onehot(m_pick)); // R2
    AST_SERVED_ARE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (m_served & ~slot_valid) == '0); // R3
    AST_NO_LOWER_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
        (m_served & (m_pick - N'(1))) == '0); // R3
    AST_OFFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ack) |=> (acc_valid && $stable(acc_be) &&
                                     $stable(acc_served) && $stable(acc_line))); // R6
    AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ack) |=> ((req_ready & $past(acc_served)) == $past(acc_served))); // R6
    AST_OFFER_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_served != '0)); // R2
endmodule

// File: tb/tb_lsm_line_merger.sv
`timescale 1ns/1ps
module tb_lsm_line_merger;
    localparam int N  = 16;
    localparam int AW = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N-1:0]      req_valid;
    logic [N*AW-1:0]   req_addr;
    logic [N*2-1:0]    req_len;
    logic [N-1:0]      req_ready;
    logic              acc_valid;
    logic [AW-6:0]     acc_line;
    logic              acc_half;
    logic [15:0]       acc_be;
    logic [N-1:0]      acc_served;
    logic              acc_ack;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] m_addr [N];
    logic [1:0]    m_len  [N];
    logic [N-1:0]  m_valid;
    logic [AW-1:0] s_addr [N];
    logic [1:0]    s_len  [N];
    logic [31:0]   seed = 32'h1234_5678;

    always #4 clk = ~clk;

    lsm_line_merger dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_ready(req_ready), .acc_valid(acc_valid),
        .acc_line(acc_line), .acc_half(acc_half), .acc_be(acc_be),
        .acc_served(acc_served), .acc_ack(acc_ack)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_mask(input logic [3:0] off, input logic [1:0] code);
        logic [15:0] m;
        int n;
        n = 1 << code;
        m = '0;
        for (int b = 0; b < 16; b++) begin
            if (b >= int'(off) && b < int'(off) + n) m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // Present requests from the staging arrays for one cycle.
    task automatic fire(input logic [N-1:0] sel);
        for (int i = 0; i < N; i++) begin
            req_addr[i*AW +: AW] = s_addr[i];
            req_len[i*2 +: 2]    = s_len[i];
            if (sel[i] && !m_valid[i]) begin
                m_valid[i] = 1'b1;
                m_addr[i]  = s_addr[i];
                m_len[i]   = s_len[i];
            end
        end
        req_valid = sel;
        @(negedge clk);
        req_valid = '0;
    endtask

    // Wait for an offer, compare with the model, acknowledge it.
    task automatic take(input string tag);
        int p;
        int waited;
        logic [N-1:0]  e_srv;
        logic [15:0]   e_be;
        waited = 0;
        while (!acc_valid && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk(acc_valid, tag, "offer present", 64'(acc_valid), 64'd1);
        p = -1;
        for (int i = N - 1; i >= 0; i--) if (m_valid[i]) p = i;
        e_srv = '0;
        e_be  = '0;
        if (p >= 0) begin
            for (int j = p; j < N; j++) begin
                if (m_valid[j] && m_addr[j][AW-1:4] == m_addr[p][AW-1:4]) begin
                    e_srv[j] = 1'b1;
                    e_be = e_be | exp_mask(m_addr[j][3:0], m_len[j]);
                end
            end
            chk(acc_line == m_addr[p][AW-1:5], tag, "line", 64'(acc_line), 64'(m_addr[p][AW-1:5]));
            chk(acc_half == m_addr[p][4], tag, "half", 64'(acc_half), 64'(m_addr[p][4]));
        end
        chk(acc_served == e_srv, tag, "served", 64'(acc_served), 64'(e_srv));
        chk(acc_be == e_be, tag, "byte enables", 64'(acc_be), 64'(e_be));
        acc_ack = 1'b1;
        @(negedge clk);
        acc_ack = 1'b0;
        m_valid = m_valid & ~acc_served;
        chk((req_ready & e_srv) == e_srv, "R6", "ready after retire",
            64'(req_ready), 64'(req_ready | e_srv));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = '0; req_addr = '0; req_len = '0; acc_ack = 1'b0;
        m_valid = '0;
        for (int i = 0; i < N; i++) begin s_addr[i] = '0; s_len[i] = '0; m_addr[i] = '0; m_len[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!acc_valid, "R1", "acc_valid", 64'(acc_valid), 64'd0);
        chk(req_ready == '1, "R1", "req_ready", 64'(req_ready), 64'hffff);

        // R5 all sizes at all offsets, single slot
        for (int c = 0; c < 4; c++) begin
            for (int off = 0; off < 16; off++) begin
                s_addr[0] = 32'h0000_4a40 | 32'(off) | (32'(c & 1) << 4);
                s_len[0]  = 2'(c);
                fire(16'h0001);
                take("R5");
            end
        end

        // R4 single-bit differences above bit 3, low bits free
        for (int b = 4; b < AW; b++) begin
            s_addr[2] = 32'h5a5a_3c00;            s_len[2] = 2'd1;
            s_addr[5] = 32'h5a5a_3c00 ^ (32'd1 << b); s_len[5] = 2'd0;
            s_addr[9] = 32'h5a5a_3c0b;            s_len[9] = 2'd2;
            fire(16'h0224);
            take("R4");
            take("R4");
        end

        // R2 R3 R9 random fills drained lowest first
        for (int r = 0; r < 60; r++) begin
            logic [N-1:0] sel;
            sel = 16'(rnd());
            for (int i = 0; i < N; i++) begin
                logic [31:0] v;
                v = rnd();
                s_addr[i] = {(v[31:30] == 2'b11) ? 1'b1 : 1'b0, 26'h0123_456, v[5], v[4:0]};
                s_len[i]  = v[9:8];
            end
            fire(sel);
            while (m_valid != '0) take("R3");
        end

        // R6 latency and hold
        s_addr[7] = 32'h0000_1234; s_len[7] = 2'd2;
        fire(16'h0080);
        chk(!acc_valid, "R6", "no offer one edge after accept", 64'(acc_valid), 64'd0);
        @(negedge clk);
        chk(acc_valid, "R6", "offer two edges after accept", 64'(acc_valid), 64'd1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(acc_valid && acc_served == 16'h0080 && acc_be == 16'h00f0, "R6",
                "held offer", 64'(acc_be), 64'h00f0);
        end
        take("R6");

        // R7 request to an occupied slot is dropped
        s_addr[3] = 32'h0000_8000; s_len[3] = 2'd0;
        fire(16'h0008);
        chk(!req_ready[3], "R7", "slot busy", 64'(req_ready[3]), 64'd0);
        s_addr[3] = 32'h0000_9008; s_len[3] = 2'd3;
        fire(16'h0008);
        take("R7");
        repeat (4) @(negedge clk);
        chk(!acc_valid, "R7", "ignored request not offered", 64'(acc_valid), 64'd0);
        chk(req_ready[3], "R7", "slot empty", 64'(req_ready[3]), 64'd1);

        // R8 write during an offer waits for the next access
        s_addr[5] = 32'h0000_2204; s_len[5] = 2'd0;
        fire(16'h0020);
        @(negedge clk);
        s_addr[2] = 32'h0000_2202; s_len[2] = 2'd0;
        for (int i = 0; i < N; i++) begin
            req_addr[i*AW +: AW] = s_addr[i];
            req_len[i*2 +: 2]    = s_len[i];
        end
        req_valid = 16'h0004;
        @(negedge clk);
        req_valid = '0;
        @(negedge clk);
        chk(acc_served == 16'h0020 && acc_be == 16'h0010, "R8", "offer unchanged",
            64'(acc_served), 64'h0020);
        take("R8");
        m_valid[2] = 1'b1; m_addr[2] = s_addr[2]; m_len[2] = s_len[2];
        take("R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule